// File: doc/BRIEF.md
# Split-Width Accumulator ALU with Flags

This block is the arithmetic and logic stage of a small signal processor. It holds a 32-bit accumulator and a 16-bit status word. On each cycle where `op_valid` is high it applies subtract, compare, add, AND, OR or XOR between the accumulator and a source operand, then updates the zero and negative flags from the result.

The width of an operation depends on where its operand comes from. A 16-bit operand drives the arithmetic operations on the upper accumulator half only, and the lower half is left as it was. For the logic operations, the same 16-bit operand is moved into the upper half and combined across all 32 bits. When the source-select code names the product register, every operation switches to a full 32-bit operation against the 32-bit product value.

The processor's decode stage drives the opcode, the source-select code and both operand buses. The new accumulator and status values appear one clock later.

Top module: `acc_alu`

## Requirements
- R1: With a 16-bit source (`src_sel` != PROD_SEL, default 7), SUB (opcode 0) and ADD (opcode 2) set acc[31:16] to acc[31:16] minus or plus `operand`, modulo 2^16, and leave acc[15:0] unchanged.
- R2: CMP (opcode 1) updates the flags exactly as SUB would for the same inputs. It never changes the accumulator.
- R3: With a 16-bit source, AND (opcode 3), OR (opcode 4) and XOR (opcode 5) combine the full accumulator with {operand, 16'h0000}. A narrow AND therefore clears acc[15:0].
- R4: When `src_sel` == PROD_SEL, all six operations use the full 32-bit `product` on the full 32-bit accumulator, and `operand` has no effect.
- R5: After SUB, CMP or ADD, Z (status bit 2) is set when the result is zero. Otherwise N (status bit 3) equals the sign of the result: bit 15 of the 16-bit result, or bit 31 of the 32-bit result. Z and N are never both set.
- R6: After AND, OR or XOR, Z is set when the 32-bit result is zero. Otherwise N equals result bit 31.
- R7: V (status bit 1) and L (status bit 0) read 0 after every operation. Status bits outside the four flag bits keep their reset value STATUS_INIT (default 16'hA500).
- R8: Reset sets the accumulator to 0 and the status word to STATUS_INIT with all four flag bits clear. A cycle with `op_valid` low, or with opcode 6 or 7, changes neither the accumulator nor the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Executes the presented operation this cycle |
| op_code | input | 3 | 0 SUB, 1 CMP, 2 ADD, 3 AND, 4 OR, 5 XOR |
| src_sel | input | 4 | Source-select code; PROD_SEL picks the product register |
| operand | input | 16 | 16-bit source operand |
| product | input | 32 | 32-bit product register value |
| acc | output | 32 | Accumulator |
| status | output | 16 | Status word with L, V, Z, N flags |

## Verification
The hardest case to reach is a narrow arithmetic operation that runs while the lower accumulator half holds a nonzero pattern. From reset, a narrow operation can only write the upper half. The stimulus therefore first runs a 32-bit add from the product register to plant a pattern in bits 15:0, and only then applies narrow add, subtract and compare to show that those bits survive. The narrow subtract is chosen so that its 16-bit result is exactly zero while the low half is nonzero. This separates the 16-bit zero test from the 32-bit zero test. Later, a narrow subtract that borrows below zero shows that the negative flag follows bit 15 of the 16-bit result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    typedef enum logic [2:0] {
        OP_SUB = 3'd0,
        OP_CMP = 3'd1,
        OP_ADD = 3'd2,
        OP_AND = 3'd3,
        OP_OR  = 3'd4,
        OP_XOR = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2
    } logic_fn_e;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
    parameter int DATA_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [ACC_W-1:0]  product_i,
    input  logic              wide_i,
    input  logic              sub_i,
    output logic [ACC_W-1:0]  acc_o,
    output logic              zero_o,
    output logic              neg_o
);
    logic [DATA_W-1:0] hi_res;
    logic [ACC_W-1:0]  full_res;

    always_comb begin
        hi_res   = sub_i ? (acc_i[ACC_W-1:DATA_W] - operand_i)
                         : (acc_i[ACC_W-1:DATA_W] + operand_i);
        full_res = sub_i ? (acc_i - product_i) : (acc_i + product_i);
        if (wide_i) begin
            acc_o  = full_res;
            zero_o = (full_res == '0);
            neg_o  = full_res[ACC_W-1];
        end else begin
            acc_o  = {hi_res, acc_i[DATA_W-1:0]};
            zero_o = (hi_res == '0);
            neg_o  = hi_res[DATA_W-1];
        end
    end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int ACC_W = 2 * DATA_W
) (
    input  logic [ACC_W-1:0]  acc_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [ACC_W-1:0]  product_i,
    input  logic              wide_i,
    input  logic_fn_e         fn_i,
    output logic [ACC_W-1:0]  res_o,
    output logic              zero_o,
    output logic              neg_o
);
    logic [ACC_W-1:0] src;

    always_comb begin
        src = wide_i ? product_i : {operand_i, {DATA_W{1'b0}}};
        unique case (fn_i)
            LF_AND:  res_o = acc_i & src;
            LF_OR:   res_o = acc_i | src;
            default: res_o = acc_i ^ src;
        endcase
        zero_o = (res_o == '0);
        neg_o  = res_o[ACC_W-1];
    end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags #(
    parameter int L_POS = 0,
    parameter int V_POS = 1,
    parameter int Z_POS = 2,
    parameter int N_POS = 3
) (
    input  logic [15:0] status_i,
    input  logic        update_i,
    input  logic        zero_i,
    input  logic        neg_i,
    output logic [15:0] status_o
);
    always_comb begin
        status_o = status_i;
        if (update_i) begin
            status_o[L_POS] = 1'b0;
            status_o[V_POS] = 1'b0;
            status_o[Z_POS] = zero_i;
            status_o[N_POS] = !zero_i && neg_i;
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int          DATA_W      = 16,
    parameter int          SEL_W       = 4,
    parameter logic [3:0]  PROD_SEL    = 4'd7,
    parameter int          L_POS       = 0,
    parameter int          V_POS       = 1,
    parameter int          Z_POS       = 2,
    parameter int          N_POS       = 3,
    parameter logic [15:0] STATUS_INIT = 16'hA500,
    localparam int         ACC_W       = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [ACC_W-1:0]  product,
    output logic [ACC_W-1:0]  acc,
    output logic [15:0]       status
);
    localparam logic [15:0] FLAG_MASK =
        (16'd1 << L_POS) | (16'd1 << V_POS) | (16'd1 << Z_POS) | (16'd1 << N_POS);
    localparam logic [15:0] STATUS_RST = STATUS_INIT & ~FLAG_MASK;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [15:0]      status;
    } state_t;

    state_t state_d, state_q;

    logic             wide;
    logic             is_arith, is_logic, is_sub, is_cmp;
    logic [ACC_W-1:0] arith_acc, logic_acc;
    logic             arith_zero, arith_neg, logic_zero, logic_neg;
    logic             flag_upd, flag_zero, flag_neg;
    logic [15:0]      status_upd;
    logic_fn_e        lfn;

    always_comb begin
        wide     = (src_sel == SEL_W'(PROD_SEL));
        is_sub   = (op_code == OP_SUB) || (op_code == OP_CMP);
        is_cmp   = (op_code == OP_CMP);
        is_arith = is_sub || (op_code == OP_ADD);
        is_logic = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
        unique case (op_code)
            OP_AND:  lfn = LF_AND;
            OP_OR:   lfn = LF_OR;
            default: lfn = LF_XOR;
        endcase
    end

    acc_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .acc_i     (state_q.acc),
        .operand_i (operand),
        .product_i (product),
        .wide_i    (wide),
        .sub_i     (is_sub),
        .acc_o     (arith_acc),
        .zero_o    (arith_zero),
        .neg_o     (arith_neg)
    );

    acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .acc_i     (state_q.acc),
        .operand_i (operand),
        .product_i (product),
        .wide_i    (wide),
        .fn_i      (lfn),
        .res_o     (logic_acc),
        .zero_o    (logic_zero),
        .neg_o     (logic_neg)
    );

    always_comb begin
        flag_upd  = op_valid && (is_arith || is_logic);
        flag_zero = is_arith ? arith_zero : logic_zero;
        flag_neg  = is_arith ? arith_neg  : logic_neg;
    end

    acc_alu_flags #(
        .L_POS(L_POS), .V_POS(V_POS), .Z_POS(Z_POS), .N_POS(N_POS)
    ) u_flags (
        .status_i (state_q.status),
        .update_i (flag_upd),
        .zero_i   (flag_zero),
        .neg_i    (flag_neg),
        .status_o (status_upd)
    );

    always_comb begin
        state_d        = state_q;
        state_d.status = status_upd;
        if (op_valid) begin
            if (is_arith && !is_cmp) begin
                state_d.acc = arith_acc;
            end else if (is_logic) begin
                state_d.acc = logic_acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.acc    <= '0;
            state_q.status <= STATUS_RST;
        end else begin
            state_q <= state_d;
        end
    end

    assign acc    = state_q.acc;
    assign status = state_q.status;

    // R1: narrow add/sub keeps the low half
    p_low_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wide && (op_code == OP_ADD || op_code == OP_SUB))
        |=> acc[DATA_W-1:0] == $past(acc[DATA_W-1:0]));

    // R2: compare never writes the accumulator
    p_cmp_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_CMP) |=> $stable(acc));

    // R3: narrow AND clears the low half
    p_and_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wide && op_code == OP_AND) |=> acc[DATA_W-1:0] == '0);

    // R5: Z and N never both set
    p_zn_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[Z_POS] && status[N_POS]));

    // R6: zero result from a logic op sets Z
    p_logic_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && is_logic) |=> (status[Z_POS] == (acc == '0)));

    // R7: non-flag status bits hold their reset value
    p_status_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~FLAG_MASK) == STATUS_RST);

    // R8: idle cycles change nothing
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc) && $stable(status)));
endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] PSEL = 4'd7;

    typedef struct {
        logic [31:0] acc;
        logic [15:0] st;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [3:0]  src_sel = '0;
    logic [15:0] operand = '0;
    logic [31:0] product = '0;
    logic [31:0] acc;
    logic [15:0] status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [31:0] m_acc = '0;
    logic [15:0] m_st  = 16'hA500;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_sel(src_sel), .operand(operand), .product(product),
        .acc(acc), .status(status)
    );

    task automatic check(input string tag, input logic [31:0] a, input logic [15:0] s,
                         input logic [31:0] ea, input logic [15:0] es);
        n_checks++;
        if (a !== ea || s !== es) begin
            n_fail++;
            $display("FAIL %s: acc=%08h status=%04h expected acc=%08h status=%04h",
                     tag, a, s, ea, es);
        end
    endtask

    // flags model: Z bit2, N bit3, V bit1, L bit0
    function automatic logic [15:0] set_flags(input logic [15:0] s, input bit z, input bit n);
        logic [15:0] r;
        r    = s & 16'hFFF0;
        r[2] = z;
        r[3] = !z && n;
        return r;
    endfunction

    task automatic drive(input string tag, input bit v, input logic [2:0] op,
                         input logic [3:0] sel, input logic [15:0] opd, input logic [31:0] prd);
        exp_t e;
        logic [15:0] h;
        logic [31:0] w, src;
        bit wide;
        @(negedge clk);
        op_valid = v; op_code = op; src_sel = sel; operand = opd; product = prd;
        wide = (sel == PSEL);
        if (v) begin
            case (op)
                3'd0, 3'd1, 3'd2: begin
                    if (wide) begin
                        w = (op == 3'd2) ? m_acc + prd : m_acc - prd;
                        m_st = set_flags(m_st, w == 0, w[31]);
                        if (op != 3'd1) m_acc = w;
                    end else begin
                        h = (op == 3'd2) ? m_acc[31:16] + opd : m_acc[31:16] - opd;
                        m_st = set_flags(m_st, h == 0, h[15]);
                        if (op != 3'd1) m_acc = {h, m_acc[15:0]};
                    end
                end
                3'd3, 3'd4, 3'd5: begin
                    src = wide ? prd : {opd, 16'h0000};
                    if (op == 3'd3)      m_acc = m_acc & src;
                    else if (op == 3'd4) m_acc = m_acc | src;
                    else                 m_acc = m_acc ^ src;
                    m_st = set_flags(m_st, m_acc == 0, m_acc[31]);
                end
                default: ;
            endcase
        end
        e.acc = m_acc; e.st = m_st; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, acc, status, e.acc, e.st);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: acc=%08h status=%04h expected completion", acc, status);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset", acc, status, 32'h0, 16'hA500);
        rst_n = 1'b1;
        drive("R1 narrow add",          1, 3'd2, 4'd1, 16'h1234, 32'hDEAD_BEEF);
        drive("R4 wide add plants low", 1, 3'd2, PSEL, 16'hFFFF, 32'h0000_ABCD);
        drive("R1 R5 narrow sub zero",  1, 3'd0, 4'd2, 16'h1234, 32'h0);
        drive("R5 narrow borrow neg",   1, 3'd0, 4'd3, 16'h0001, 32'h0);
        drive("R2 narrow cmp equal",    1, 3'd1, 4'd0, 16'hFFFF, 32'h0);
        drive("R2 narrow cmp greater",  1, 3'd1, 4'd0, 16'h0005, 32'h0);
        drive("R2 R4 wide cmp",         1, 3'd1, PSEL, 16'h0000, 32'h0000_0001);
        drive("R8 invalid ignored",     0, 3'd2, 4'd1, 16'h7777, 32'h1);
        drive("R8 opcode 6 ignored",    1, 3'd6, 4'd1, 16'h7777, 32'h1);
        drive("R8 opcode 7 ignored",    1, 3'd7, PSEL, 16'h7777, 32'h1);
        drive("R3 narrow or",           1, 3'd4, 4'd5, 16'h00F0, 32'h0);
        drive("R3 R6 narrow xor",       1, 3'd5, 4'd5, 16'h8000, 32'h0);
        drive("R3 narrow and clears",   1, 3'd3, 4'd5, 16'hF0F0, 32'h0);
        drive("R4 wide or",             1, 3'd4, PSEL, 16'h0000, 32'h8000_1234);
        drive("R4 R6 wide and",         1, 3'd3, PSEL, 16'hFFFF, 32'h8000_0004);
        drive("R4 R6 wide xor zero",    1, 3'd5, PSEL, 16'h1111, 32'h8000_0004);
        drive("R4 R5 wide sub neg",     1, 3'd0, PSEL, 16'h0000, 32'h0000_0003);
        drive("R4 R5 wide add zero",    1, 3'd2, PSEL, 16'h0000, 32'h0000_0003);
        drive("R1 R7 narrow add wrap",  1, 3'd2, 4'd0, 16'h8000, 32'h0);
        drive("R1 R7 narrow add wrap2", 1, 3'd2, 4'd0, 16'h8001, 32'h0);
        drive("R8 idle",                0, 3'd0, 4'd0, 16'h0, 32'h0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule